// File: doc/BRIEF.md
# Thermal Fan Speed Supervisor

This block watches two digitized temperature readings, one from the power supply and one from the processor stack. From the power-supply reading alone it picks one of three speeds for a pair of variable-speed cooling fans. The speed goes up through fixed thresholds and comes back down only after the reading has fallen a few degrees below the threshold that raised it. While the top speed is commanded, a warning flag tells the user that a shutdown will follow if the heating continues.

Each sensor also has its own trip limit. A reading above either limit raises a shutdown request and lights an indicator bit that names the sensor responsible. The request and the indicators stay set until reset. Readings are signed whole degrees Celsius, and each reading is used only in a cycle where its valid strobe is high.

Top module: `thermal_fan_supervisor`

## Requirements
- R1: After reset, `fan_speed` is 2'b00 (low), and `warn_high`, `shutdown_req`, `trip_psu` and `trip_cpu` are all 0.
- R2: With the fans at low speed, a valid power-supply reading above 39 selects medium speed (2'b01) in the next cycle. A reading of 39 keeps low speed.
- R3: A valid power-supply reading above 51 selects high speed (2'b10) in the next cycle, from low or from medium. A reading of 51 does not.
- R4: The speed falls only when the reading has dropped 3 degrees below the threshold that raised it. High speed is held down to 49 and left at 48 or below. Medium speed is held down to 37 and left at 36 or below. A single reading can drop the speed straight from high to low.
- R5: A reading whose valid strobe is low has no effect on the speed, the shutdown request or the indicators.
- R6: `warn_high` is 1 exactly while `fan_speed` is high. The code 2'b11 is never output.
- R7: The processor-stack reading never changes `fan_speed`.
- R8: A valid power-supply reading above 97 sets `shutdown_req` and `trip_psu` in the next cycle. A valid processor-stack reading above 100 sets `shutdown_req` and `trip_cpu` in the next cycle. Readings of exactly 97 and 100 trip nothing.
- R9: `shutdown_req` and the indicator bits stay set until reset, whatever later readings arrive. When both limits are exceeded in the same cycle, both indicator bits are set.
- R10: Readings are signed two's complement, so a negative power-supply reading counts as cold and selects low speed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psu_temp | input | TEMP_W | Power-supply temperature, signed degrees C |
| psu_valid | input | 1 | psu_temp is valid in this cycle |
| cpu_temp | input | TEMP_W | Processor-stack temperature, signed degrees C |
| cpu_valid | input | 1 | cpu_temp is valid in this cycle |
| fan_speed | output | 2 | Speed for both fans: 00 low, 01 medium, 10 high |
| warn_high | output | 1 | High speed is being commanded |
| shutdown_req | output | 1 | Latched shutdown request |
| trip_psu | output | 1 | Latched: the power-supply limit was exceeded |
| trip_cpu | output | 1 | Latched: the processor-stack limit was exceeded |

## Verification
The assertions check on every cycle that the speed code is legal and stays put when no valid reading arrives. They also check that every rise to high speed was caused by a reading above the upper threshold, that every drop in speed came from a reading at or below the hysteresis point, and that a tripped indicator stays set and was raised by a reading above its limit. Only the bench scenarios can show the exact threshold boundaries (39/40, 51/52, 48/49, 36/37, 97/98, 100/101), that the processor-stack reading has no effect on speed, that signed negative readings count as cold, and that two limits exceeded in the same cycle set both indicators.

// File: rtl/therm_pkg.sv
package therm_pkg;

  typedef enum logic [1:0] {
    SPD_LOW  = 2'b00,
    SPD_MED  = 2'b01,
    SPD_HIGH = 2'b10
  } speed_e;

  // Threshold that must be exceeded to hold or enter a given level.
  function automatic int level_floor(speed_e lvl, int med_on, int high_on);
    case (lvl)
      SPD_MED:  return med_on;
      SPD_HIGH: return high_on;
      default:  return -32768;
    endcase
  endfunction

  // Next speed from the current speed and one valid reading.
  function automatic speed_e next_speed(speed_e cur, int t, int med_on,
                                        int high_on, int hyst);
    int high_keep;
    int med_keep;
    high_keep = (cur == SPD_HIGH) ? high_on - hyst : high_on;
    med_keep  = (cur != SPD_LOW)  ? med_on - hyst  : med_on;
    if (t > high_keep)     return SPD_HIGH;
    else if (t > med_keep) return SPD_MED;
    else                   return SPD_LOW;
  endfunction

  function automatic logic over_limit(int t, int limit);
    return t > limit;
  endfunction

endpackage

// File: rtl/fan_speed_ctrl.sv
module fan_speed_ctrl
  import therm_pkg::*;
#(
  parameter int TEMP_W  = 10,
  parameter int MED_ON  = 39,
  parameter int HIGH_ON = 51,
  parameter int HYST    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [TEMP_W-1:0] temp,
  input  logic                     valid,
  output speed_e                   speed
);

  int     temp_i;
  speed_e speed_nxt;
  logic   step_up_evt;
  logic   step_down_evt;

  assign temp_i    = int'(temp);
  assign speed_nxt = next_speed(speed, temp_i, MED_ON, HIGH_ON, HYST);

  assign step_up_evt   = valid && (speed_nxt > speed);
  assign step_down_evt = valid && (speed_nxt < speed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed <= SPD_LOW;
    end else if (valid) begin
      speed <= speed_nxt;
    end
  end

  AST_SPEED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    speed != 2'b11); // R6

  AST_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(speed)); // R5

  AST_HIGH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && speed != SPD_HIGH && temp_i > HIGH_ON) |=> speed == SPD_HIGH); // R3

  AST_DROP_HYST: assert property (@(posedge clk) disable iff (!rst_n)
    step_down_evt |-> temp_i <= level_floor(speed, MED_ON, HIGH_ON) - HYST); // R4

  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_up_evt |-> temp_i > MED_ON); // R2

endmodule

// File: rtl/trip_latch.sv
module trip_latch
  import therm_pkg::*;
#(
  parameter int TEMP_W = 10,
  parameter int LIMIT  = 97
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [TEMP_W-1:0] temp,
  input  logic                     valid,
  output logic                     tripped
);

  logic trip_evt;

  assign trip_evt = valid && over_limit(int'(temp), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripped <= 1'b0;
    end else if (trip_evt) begin
      tripped <= 1'b1;
    end
  end

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |=> tripped); // R9

  AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !tripped ##1 tripped |-> $past(valid) && int'($past(temp)) > LIMIT); // R8

  AST_TRIP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tripped && !valid) |=> !tripped); // R5

endmodule

// File: rtl/thermal_fan_supervisor.sv
module thermal_fan_supervisor
  import therm_pkg::*;
#(
  parameter int TEMP_W   = 10,
  parameter int MED_ON   = 39,
  parameter int HIGH_ON  = 51,
  parameter int HYST     = 3,
  parameter int PSU_TRIP = 97,
  parameter int CPU_TRIP = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] psu_temp,
  input  logic              psu_valid,
  input  logic [TEMP_W-1:0] cpu_temp,
  input  logic              cpu_valid,
  output logic [1:0]        fan_speed,
  output logic              warn_high,
  output logic              shutdown_req,
  output logic              trip_psu,
  output logic              trip_cpu
);

  localparam int NSENS = 2;
  localparam int LIMITS [NSENS] = '{PSU_TRIP, CPU_TRIP};

  speed_e                    speed;
  logic signed [TEMP_W-1:0]  s_temp  [NSENS];
  logic                      s_valid [NSENS];
  logic                      s_trip  [NSENS];

  assign s_temp[0]  = $signed(psu_temp);
  assign s_temp[1]  = $signed(cpu_temp);
  assign s_valid[0] = psu_valid;
  assign s_valid[1] = cpu_valid;

  fan_speed_ctrl #(
    .TEMP_W (TEMP_W),
    .MED_ON (MED_ON),
    .HIGH_ON(HIGH_ON),
    .HYST   (HYST)
  ) u_fan (
    .clk  (clk),
    .rst_n(rst_n),
    .temp (s_temp[0]),
    .valid(psu_valid),
    .speed(speed)
  );

  for (genvar g = 0; g < NSENS; g++) begin : g_sensor
    trip_latch #(
      .TEMP_W(TEMP_W),
      .LIMIT (LIMITS[g])
    ) u_trip (
      .clk    (clk),
      .rst_n  (rst_n),
      .temp   (s_temp[g]),
      .valid  (s_valid[g]),
      .tripped(s_trip[g])
    );
  end

  assign fan_speed    = speed;
  assign warn_high    = (speed == SPD_HIGH);
  assign trip_psu     = s_trip[0];
  assign trip_cpu     = s_trip[1];
  assign shutdown_req = s_trip[0] | s_trip[1];

  AST_CPU_NO_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
    (!psu_valid && cpu_valid) |=> $stable(fan_speed)); // R7

  AST_SD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> shutdown_req); // R9

endmodule

// File: tb/test_thermal_fan_supervisor.sv
module test_thermal_fan_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 10;
  localparam int NV = 16;
  // columns: psu_temp, psu_valid, cpu_temp, cpu_valid, expected speed code
  localparam int VEC [NV][5] = '{
    '{30, 1, 50, 1, 0},   // R1 stays low
    '{39, 1, 50, 1, 0},   // R2 boundary
    '{40, 1, 50, 1, 1},   // R2 step to medium
    '{37, 1, 50, 1, 1},   // R4 medium held
    '{36, 1, 50, 1, 0},   // R4 medium left
    '{45, 1, 50, 1, 1},   // R2
    '{51, 1, 50, 1, 1},   // R3 boundary
    '{52, 1, 50, 1, 2},   // R3 step to high
    '{49, 1, 50, 1, 2},   // R4 high held
    '{48, 1, 50, 1, 1},   // R4 high left
    '{60, 0, 50, 1, 1},   // R5 ignored
    '{60, 1, 50, 1, 2},   // R3 medium to high
    '{20, 1, 50, 1, 0},   // R4 high straight to low
    '{20, 1, 99, 1, 0},   // R7 cpu reading no speed effect
    '{-5, 1, 99, 1, 0},   // R10 negative is cold
    '{99, 0, 120, 0, 0}   // R5 invalid hot readings ignored
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] psu_temp = '0;
  logic          psu_valid = 1'b0;
  logic [TW-1:0] cpu_temp = '0;
  logic          cpu_valid = 1'b0;
  logic [1:0]    fan_speed;
  logic          warn_high, shutdown_req, trip_psu, trip_cpu;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_fan_supervisor #(.TEMP_W(TW)) i_thermal_fan_supervisor (
    .clk(clk), .rst_n(rst_n),
    .psu_temp(psu_temp), .psu_valid(psu_valid),
    .cpu_temp(cpu_temp), .cpu_valid(cpu_valid),
    .fan_speed(fan_speed), .warn_high(warn_high),
    .shutdown_req(shutdown_req), .trip_psu(trip_psu), .trip_cpu(trip_cpu)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; psu_valid = 1'b0; cpu_valid = 1'b0;
    psu_temp = '0; cpu_temp = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive at a falling edge, one rising edge registers it, sample at next fall
  task automatic apply(int pt, int pv, int ct, int cv);
    psu_temp  = TW'(pt);
    psu_valid = pv[0];
    cpu_temp  = TW'(ct);
    cpu_valid = cv[0];
    @(negedge clk);
  endtask

  task automatic check_trip(string req, int sd, int tp, int tc);
    check(req, "shutdown_req", int'(shutdown_req), sd);
    check(req, "trip_psu", int'(trip_psu), tp);
    check(req, "trip_cpu", int'(trip_cpu), tc);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", "fan_speed", int'(fan_speed), 0);
    check("R1", "warn_high", int'(warn_high), 0);
    check_trip("R1", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      check($sformatf("R2-table vec%0d", i), "fan_speed", int'(fan_speed), VEC[i][4]);
      check("R6", "warn_high", int'(warn_high), (VEC[i][4] == 2) ? 1 : 0);
      check("R5", "shutdown_req", int'(shutdown_req), 0);
    end

    // R8 power-supply limit boundary and R9 latching
    apply(97, 1, 20, 1);
    check_trip("R8", 0, 0, 0);
    apply(98, 1, 20, 1);
    check_trip("R8", 1, 1, 0);
    check("R3", "fan_speed", int'(fan_speed), 2);
    apply(20, 1, 20, 1);
    check_trip("R9", 1, 1, 0);
    apply(20, 0, 20, 0);
    check_trip("R9", 1, 1, 0);

    // R8 processor-stack limit
    do_reset();
    check_trip("R1", 0, 0, 0);
    apply(20, 1, 100, 1);
    check_trip("R8", 0, 0, 0);
    apply(20, 1, 130, 0);
    check_trip("R5", 0, 0, 0);
    apply(20, 1, 101, 1);
    check_trip("R8", 1, 0, 1);
    check("R7", "fan_speed", int'(fan_speed), 0);
    apply(20, 1, 20, 1);
    check_trip("R9", 1, 0, 1);

    // R9 both limits in one cycle
    do_reset();
    apply(120, 1, 120, 1);
    check_trip("R9", 1, 1, 1);
    check("R6", "warn_high", int'(warn_high), 1);

    // R10 large negative reading from high speed
    apply(-100, 1, 20, 1);
    check("R10", "fan_speed", int'(fan_speed), 0);
    check_trip("R9", 1, 1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule